// File: doc/BRIEF.md
# Multi-master arbitration monitor

This block runs beside the transmit side of a two-wire open-drain bus master. It watches the shared clock and data lines through its own synchronisers. While this master still owns the bus, it checks every data bit the master releases (sends as 1) against the level the bus actually shows while the clock is high. The wired-AND bus reads 0 when any device pulls it low. So a released 1 that reads back as 0 means another master is also transmitting, and this master has lost arbitration.

When arbitration is lost, the data driver is released at once and stays released until the flag is cleared. The clock-generation permit stays asserted until the byte-boundary strobe marks the end of the byte, 8 data bits plus acknowledge. Control then passes to a slave-receive path. A parameter sets when that hand-over is requested: together with the loss, at the end of the byte, or never for a master with no slave function. The comparison does not stop at the address byte; it runs through every byte of the transfer. The block also flags a collision between conditions, where this master sends a repeated START or STOP and the bus shows something else during that clock-high phase.

Top module: `arbmon_top`

## Requirements
- R1: After reset, `sda_drive_low_o`, `scl_run_o`, `arb_lost_o`, `to_slave_o` and `proto_err_o` are all 0.
- R2: While `xfer_active_i` is 1 and arbitration is not lost, `sda_drive_low_o` equals the inverse of `tx_bit_i` (a 0 bit pulls the line low) and `scl_run_o` is 1.
- R3: With `tx_kind_i` = 2'b00 (data bit), `tx_bit_i` = 1 and a synchronised clock level of 1, a synchronised data level of 0 sets `arb_lost_o`. The flag is set SYNC_STAGES+1 clock cycles after the raw bus change.
- R4: No loss is flagged while this master sends a 0, or while the synchronised clock is low.
- R5: While `arb_lost_o` is 1, `sda_drive_low_o` is 0 whatever `tx_bit_i` is.
- R6: After a loss, `scl_run_o` stays 1 until `byte_end_i` pulses. From the next cycle it is 0 until the loss is cleared.
- R7: With HANDOFF = 2, `to_slave_o` rises in the cycle after `byte_end_i` ends a byte in which arbitration was lost. With HANDOFF = 1, it rises together with `arb_lost_o`. With HANDOFF = 0, it stays 0. It is never 1 without `arb_lost_o`.
- R8: A `byte_end_i` pulse without a loss does not stop clocking. Arbitration checking continues in the following bytes.
- R9: `tx_kind_i` encodes 2'b00 data, 2'b01 repeated START and 2'b10 STOP. The bus event in a clock-high phase is a START (data falls), a STOP (data rises) or a data bit (no change by the clock fall). If the event differs from what this master sends, `proto_err_o` is set.
- R10: A pulse on `lost_clr_i` or `start_issue_i` clears `arb_lost_o`, `to_slave_o` and `proto_err_o` in the next cycle and restores `scl_run_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sda_i | input | 1 | Raw data line level |
| bus_scl_i | input | 1 | Raw clock line level |
| xfer_active_i | input | 1 | This master is running a transfer |
| tx_bit_i | input | 1 | Level this master wants on the data line |
| tx_kind_i | input | 2 | What the master sends in this clock phase (00 data, 01 repeated START, 10 STOP) |
| byte_end_i | input | 1 | Strobe after the ninth clock pulse of a byte |
| start_issue_i | input | 1 | A new START is being issued |
| lost_clr_i | input | 1 | Software clear of the loss and error flags |
| sda_drive_low_o | output | 1 | Pull the data line low |
| scl_run_o | output | 1 | Clock generation permitted |
| arb_lost_o | output | 1 | Arbitration lost (sticky) |
| to_slave_o | output | 1 | Request to switch to slave-receive |
| proto_err_o | output | 1 | Condition collision seen (sticky) |

## Verification
The bench builds two copies side by side with SYNC_STAGES = 2. One uses HANDOFF = 2 and the other HANDOFF = 1, and the same stimulus drives both. This shows the two hand-over points in one run: a request at the moment of loss, and a request only after the byte-boundary strobe. The short synchroniser keeps loss latency small enough to check with fixed waits. The multi-byte, condition-collision and clear scenarios run in both copies and exercise the shared control path.

// File: rtl/arbmon_pkg.sv
package arbmon_pkg;
   typedef enum logic [1:0] {
      KIND_DATA   = 2'b00,
      KIND_RSTART = 2'b01,
      KIND_STOP   = 2'b10
   } bit_kind_t;
endpackage

// File: rtl/arbmon_sync.sv
module arbmon_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   // idle bus lines rest high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '1;
      else        stage_q[0] <= d_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= '1;
         else        stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/arbmon_phase.sv
module arbmon_phase
   import arbmon_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      s_sda_i,
   input  logic      s_scl_i,
   input  logic      xfer_active_i,
   input  bit_kind_t kind_i,
   output logic      clash_o
);
   logic      p_sda, p_scl;
   logic      armed_q, edge_seen_q;
   bit_kind_t want_q;
   logic      scl_rise, scl_fall, in_high, sda_edge;
   bit_kind_t seen_kind;

   assign scl_rise  = s_scl_i & ~p_scl;
   assign scl_fall  = ~s_scl_i & p_scl;
   assign in_high   = s_scl_i & p_scl;
   assign sda_edge  = s_sda_i ^ p_sda;
   assign seen_kind = s_sda_i ? KIND_STOP : KIND_RSTART;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_sda       <= 1'b1;
         p_scl       <= 1'b1;
         armed_q     <= 1'b0;
         edge_seen_q <= 1'b0;
         want_q      <= KIND_DATA;
      end else begin
         p_sda <= s_sda_i;
         p_scl <= s_scl_i;
         if (scl_rise) begin
            want_q      <= kind_i;
            armed_q     <= xfer_active_i;
            edge_seen_q <= 1'b0;
         end else begin
            if (in_high && sda_edge) edge_seen_q <= 1'b1;
            if (scl_fall)            armed_q     <= 1'b0;
         end
      end
   end

   always_comb begin
      clash_o = 1'b0;
      if (armed_q && !edge_seen_q) begin
         if (in_high && sda_edge && (seen_kind != want_q)) clash_o = 1'b1;
         if (scl_fall && (want_q != KIND_DATA))            clash_o = 1'b1;
      end
   end
endmodule

// File: rtl/arbmon_ctrl.sv
module arbmon_ctrl
   import arbmon_pkg::*;
#(
   parameter int HANDOFF = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      s_sda_i,
   input  logic      s_scl_i,
   input  logic      xfer_active_i,
   input  logic      tx_bit_i,
   input  bit_kind_t kind_i,
   input  logic      byte_end_i,
   input  logic      clear_i,
   input  logic      clash_i,
   output logic      drive_low_o,
   output logic      scl_run_o,
   output logic      lost_o,
   output logic      to_slave_o,
   output logic      err_o
);
   logic lost_q, tail_done_q, err_q;
   logic mismatch;

   // only a released 1 can be overridden on a wired-AND line
   assign mismatch = xfer_active_i & ~lost_q & s_scl_i & tx_bit_i &
                     (kind_i == KIND_DATA) & ~s_sda_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_q      <= 1'b0;
         tail_done_q <= 1'b0;
         err_q       <= 1'b0;
      end else if (clear_i) begin
         lost_q      <= 1'b0;
         tail_done_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         if (mismatch)                 lost_q      <= 1'b1;
         if (lost_q && byte_end_i)     tail_done_q <= 1'b1;
         if (clash_i && !lost_q && xfer_active_i) err_q <= 1'b1;
      end
   end

   assign drive_low_o = xfer_active_i & ~lost_q & ~tx_bit_i;
   assign scl_run_o   = xfer_active_i & ~(lost_q & tail_done_q);
   assign lost_o      = lost_q;
   assign err_o       = err_q;

   if (HANDOFF == 1) begin : g_handoff_now
      assign to_slave_o = lost_q;
   end else if (HANDOFF == 2) begin : g_handoff_byte
      assign to_slave_o = lost_q & tail_done_q;
   end else begin : g_handoff_none
      assign to_slave_o = 1'b0;
   end
endmodule

// File: rtl/arbmon_top.sv
module arbmon_top
   import arbmon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HANDOFF     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sda_i,
   input  logic       bus_scl_i,
   input  logic       xfer_active_i,
   input  logic       tx_bit_i,
   input  logic [1:0] tx_kind_i,
   input  logic       byte_end_i,
   input  logic       start_issue_i,
   input  logic       lost_clr_i,
   output logic       sda_drive_low_o,
   output logic       scl_run_o,
   output logic       arb_lost_o,
   output logic       to_slave_o,
   output logic       proto_err_o
);
   localparam int LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("arbmon_top: SYNC_STAGES must be at least 2");
   end
   if (HANDOFF < 0 || HANDOFF > 2) begin : g_bad_handoff
      $error("arbmon_top: HANDOFF must be 0, 1 or 2");
   end

   logic [LINES-1:0] raw_lines, sync_lines;
   logic             s_sda, s_scl, clash;
   bit_kind_t        kind;

   assign raw_lines = {bus_scl_i, bus_sda_i};
   assign s_sda     = sync_lines[0];
   assign s_scl     = sync_lines[1];
   assign kind      = bit_kind_t'(tx_kind_i);

   arbmon_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   arbmon_phase u_phase (
      .clk           (clk),
      .rst_n         (rst_n),
      .s_sda_i       (s_sda),
      .s_scl_i       (s_scl),
      .xfer_active_i (xfer_active_i),
      .kind_i        (kind),
      .clash_o       (clash)
   );

   arbmon_ctrl #(.HANDOFF(HANDOFF)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .s_sda_i       (s_sda),
      .s_scl_i       (s_scl),
      .xfer_active_i (xfer_active_i),
      .tx_bit_i      (tx_bit_i),
      .kind_i        (kind),
      .byte_end_i    (byte_end_i),
      .clear_i       (lost_clr_i | start_issue_i),
      .clash_i       (clash),
      .drive_low_o   (sda_drive_low_o),
      .scl_run_o     (scl_run_o),
      .lost_o        (arb_lost_o),
      .to_slave_o    (to_slave_o),
      .err_o         (proto_err_o)
   );
endmodule

// File: rtl/arbmon_chk.sv
module arbmon_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       xfer_active_i,
   input logic       tx_bit_i,
   input logic [1:0] tx_kind_i,
   input logic       byte_end_i,
   input logic       start_issue_i,
   input logic       lost_clr_i,
   input logic       sda_drive_low_o,
   input logic       scl_run_o,
   input logic       arb_lost_o,
   input logic       to_slave_o,
   input logic       proto_err_o
);
   AST_NO_DRIVE_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost_o |-> !sda_drive_low_o); // R5

   AST_LOSS_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost_o) |-> $past(xfer_active_i && tx_bit_i && tx_kind_i == 2'b00)); // R3

   AST_CLOCK_CUT_AT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost_o && byte_end_i && !lost_clr_i && !start_issue_i) |=> !scl_run_o); // R6

   AST_SLAVE_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      to_slave_o |-> arb_lost_o); // R7

   AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_clr_i || start_issue_i) |=> (!arb_lost_o && !proto_err_o && !to_slave_o)); // R10
endmodule

bind arbmon_top arbmon_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .xfer_active_i   (xfer_active_i),
   .tx_bit_i        (tx_bit_i),
   .tx_kind_i       (tx_kind_i),
   .byte_end_i      (byte_end_i),
   .start_issue_i   (start_issue_i),
   .lost_clr_i      (lost_clr_i),
   .sda_drive_low_o (sda_drive_low_o),
   .scl_run_o       (scl_run_o),
   .arb_lost_o      (arb_lost_o),
   .to_slave_o      (to_slave_o),
   .proto_err_o     (proto_err_o)
);

// File: tb/tb_arbmon_top.sv
module tb_arbmon_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sda = 1'b1, bus_scl = 1'b0;
   logic       xfer = 1'b0, tx = 1'b1;
   logic [1:0] kind = 2'b00;
   logic       byte_end = 1'b0, start_issue = 1'b0, lost_clr = 1'b0;
   logic       drive_low, scl_run, lost, to_slave, perr;
   logic       n_drive_low, n_scl_run, n_lost, n_to_slave, n_perr;
   int         n_checks = 0, n_fails = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   arbmon_top #(.SYNC_STAGES(2), .HANDOFF(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sda_i(bus_sda), .bus_scl_i(bus_scl),
      .xfer_active_i(xfer), .tx_bit_i(tx), .tx_kind_i(kind),
      .byte_end_i(byte_end), .start_issue_i(start_issue), .lost_clr_i(lost_clr),
      .sda_drive_low_o(drive_low), .scl_run_o(scl_run), .arb_lost_o(lost),
      .to_slave_o(to_slave), .proto_err_o(perr));

   arbmon_top #(.SYNC_STAGES(2), .HANDOFF(1)) dut_now (
      .clk(clk), .rst_n(rst_n), .bus_sda_i(bus_sda), .bus_scl_i(bus_scl),
      .xfer_active_i(xfer), .tx_bit_i(tx), .tx_kind_i(kind),
      .byte_end_i(byte_end), .start_issue_i(start_issue), .lost_clr_i(lost_clr),
      .sda_drive_low_o(n_drive_low), .scl_run_o(n_scl_run), .arb_lost_o(n_lost),
      .to_slave_o(n_to_slave), .proto_err_o(n_perr));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic pulse_clear(input bit use_start);
      if (use_start) start_issue = 1'b1; else lost_clr = 1'b1;
      tick(1);
      start_issue = 1'b0; lost_clr = 1'b0;
      tick(1);
   endtask

   task automatic t_reset();
      chk("R1", "drive_low", drive_low, 1'b0);
      chk("R1", "scl_run", scl_run, 1'b0);
      chk("R1", "lost", lost, 1'b0);
      chk("R1", "to_slave", to_slave, 1'b0);
      chk("R1", "proto_err", perr, 1'b0);
   endtask

   task automatic t_drive();
      xfer = 1'b1; kind = 2'b00; tx = 1'b0; #1;
      chk("R2", "drive_low for 0", drive_low, 1'b1);
      chk("R2", "scl_run owned", scl_run, 1'b1);
      tx = 1'b1; #1;
      chk("R2", "drive_low for 1", drive_low, 1'b0);
      tick(1);
   endtask

   task automatic t_no_loss();
      tx = 1'b0; bus_sda = 1'b0; bus_scl = 1'b1; tick(5);
      chk("R4", "no loss sending 0", lost, 1'b0);
      bus_scl = 1'b0; tick(4);
      tx = 1'b1; tick(5);
      chk("R4", "no loss with clock low", lost, 1'b0);
      bus_sda = 1'b1; tick(4);
   endtask

   task automatic t_loss_and_tail();
      tx = 1'b1; bus_scl = 1'b1; tick(5);
      chk("R3", "bus agrees, no loss", lost, 1'b0);
      bus_sda = 1'b0; tick(3);
      chk("R3", "loss after sync+1", lost, 1'b1);
      chk("R7", "handoff=2 waits for byte end", to_slave, 1'b0);
      chk("R7", "handoff=1 requests at once", n_to_slave, 1'b1);
      chk("R6", "clock continues after loss", scl_run, 1'b1);
      tx = 1'b0; #1;
      chk("R5", "no drive after loss", drive_low, 1'b0);
      bus_scl = 1'b0; tick(4); bus_scl = 1'b1; tick(4);
      chk("R6", "clock still running mid byte", scl_run, 1'b1);
      byte_end = 1'b1; tick(1); byte_end = 1'b0;
      chk("R6", "clock cut after byte end", scl_run, 1'b0);
      chk("R7", "handoff=2 after byte end", to_slave, 1'b1);
      bus_scl = 1'b0; bus_sda = 1'b1; tick(4);
      pulse_clear(1'b0);
      chk("R10", "lost cleared", lost, 1'b0);
      chk("R10", "to_slave cleared", to_slave, 1'b0);
      chk("R10", "to_slave cleared handoff=1", n_to_slave, 1'b0);
      chk("R10", "clock restored", scl_run, 1'b1);
   endtask

   task automatic t_multi_byte();
      tx = 1'b1;
      byte_end = 1'b1; tick(1); byte_end = 1'b0; tick(1);
      chk("R8", "byte end without loss keeps clock", scl_run, 1'b1);
      chk("R8", "no loss at byte end", lost, 1'b0);
      bus_scl = 1'b1; tick(4);
      bus_sda = 1'b0; tick(4);
      chk("R8", "loss in later byte", lost, 1'b1);
      bus_scl = 1'b0; bus_sda = 1'b1; tick(4);
      pulse_clear(1'b1);
      chk("R10", "start clears lost", lost, 1'b0);
   endtask

   task automatic t_proto();
      kind = 2'b01; tx = 1'b1; tick(4);
      bus_scl = 1'b1; tick(5);
      bus_scl = 1'b0; tick(5);
      chk("R9", "rstart vs data bit", perr, 1'b1);
      chk("R9", "no loss on condition", lost, 1'b0);
      pulse_clear(1'b0);
      chk("R10", "error cleared", perr, 1'b0);

      kind = 2'b10; tx = 1'b0; bus_sda = 1'b0; tick(4);
      bus_scl = 1'b1; tick(5);
      tx = 1'b1; bus_sda = 1'b1; tick(5);
      chk("R9", "matching stop no error", perr, 1'b0);
      bus_scl = 1'b0; tick(5);
      chk("R9", "no error after matched stop", perr, 1'b0);

      kind = 2'b10; tick(4);
      bus_scl = 1'b1; tick(5);
      bus_sda = 1'b0; tick(5);
      chk("R9", "stop vs start", perr, 1'b1);
      bus_scl = 1'b0; bus_sda = 1'b1; tick(4);
      pulse_clear(1'b0);

      kind = 2'b00; tx = 1'b0; bus_sda = 1'b0; tick(4);
      bus_scl = 1'b1; tick(5);
      bus_sda = 1'b1; tick(5);
      chk("R9", "data vs stop", perr, 1'b1);
      bus_scl = 1'b0; tick(4);
      pulse_clear(1'b0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      tick(5);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_drive();
      t_no_loss();
      t_loss_and_tail();
      t_multi_byte();
      t_proto();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule